// File: doc/BRIEF.md
# Fast Ethernet Transmit Coding Sublayer

This block sits between a MAC's 4-bit transmit path and the line side of a 100 Mb/s copper port. Each transmit-clock cycle it samples a frame-enable, an error flag and one data nibble, and it produces one 5-bit code group. Between frames it sends idle. When a frame opens, the two nibbles of the first preamble octet are replaced by the start delimiter pair J, K. The nibbles that follow are mapped through the 4B/5B table, or replaced by the error code group while the error flag is high. When the enable drops, the end delimiter pair T, R is sent and idle resumes.

An optional stream scrambler, chosen by a parameter, XORs the code groups with the output of an 11-bit linear feedback shift register before they leave the block. Serialisation, line coding and the analog drivers belong to the next stage. One input cycle produces one output code group, and that group appears one clock later.

Top module: `fe_tx_pcs`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge returns the framing logic to its between-frames state, and the unscrambled output after that edge is idle (11111). A frame in progress is dropped. If `tx_en` is high at the first edge after release, that edge starts a new frame with J.
- R2: While no frame is open and `tx_en` is low, every output code group is idle (11111).
- R3: The edge at which `tx_en` is first seen high emits J (11000). The next edge emits K (10001) whatever `txd` holds. Together these replace the first preamble octet.
- R4: Once J and K have been sent, each edge with `tx_en` high and `tx_er` low emits the 4B/5B code of `txd`. The codes for 0 through F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: After J and K, an edge with both `tx_en` and `tx_er` high emits the error code group H (00100) in place of the data code.
- R6: The first edge after J and K at which `tx_en` is low emits T (01101). The following edge emits R (00111) whatever the inputs hold. Idle follows.
- R7: `tx_er` has no effect while no frame is open. With `tx_en` low, idle continues.
- R8: If `tx_en` is low at the edge that would send K, T is emitted instead, and then R. The frame is cut short.
- R9: With `SCR_EN`=1, the output is the code group XOR a 5-bit key. The key is the next five feedback bits of an 11-bit register s. Each feedback bit is b = s[10]^s[8] (x^11+x^9+1), and s shifts to {s[9:0], b}. The first bit goes to output bit 4. Reset loads s with `SCR_SEED` (default 0x5A5), and s advances five steps at every edge out of reset. With `SCR_EN`=0, the plain code group is output.
- R10: A high `tx_er` during the J or K edge does not change the delimiters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag from the MAC |
| txd | input | 4 | Transmit data nibble |
| tx_sym | output | 5 | Code group, scrambled when SCR_EN=1 |

## Verification
A framing state that is out of step shows at the ports on the very next edge. Data appearing where K belongs, a missing T/R pair, or a delimiter appearing where data belongs each corrupt the first code group after the faulty transition, because every state decision is registered straight into the output. A wrong table entry or a slipped error substitution corrupts exactly one code group, one clock after the nibble is sampled. A wrong scrambler tap, seed or bit order shows up as a key mismatch on the first output after reset, and that mismatch persists on every later group.

// File: rtl/fe_pcs_pkg.sv
package fe_pcs_pkg;
   localparam int NIB_W = 4;
   localparam int SYM_W = 5;

   typedef logic [NIB_W-1:0] nib_t;
   typedef logic [SYM_W-1:0] sym_t;

   localparam sym_t SYM_IDLE = 5'b11111;
   localparam sym_t SYM_J    = 5'b11000;
   localparam sym_t SYM_K    = 5'b10001;
   localparam sym_t SYM_T    = 5'b01101;
   localparam sym_t SYM_R    = 5'b00111;
   localparam sym_t SYM_H    = 5'b00100;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_K    = 2'd1,
      ST_DATA = 2'd2,
      ST_R    = 2'd3
   } frm_state_t;
endpackage

// File: rtl/fe_tx_enc4b5b.sv
module fe_tx_enc4b5b
   import fe_pcs_pkg::*;
(
   input  nib_t nib,
   output sym_t code
);
   always_comb begin
      unique case (nib)
         4'h0: code = 5'b11110;
         4'h1: code = 5'b01001;
         4'h2: code = 5'b10100;
         4'h3: code = 5'b10101;
         4'h4: code = 5'b01010;
         4'h5: code = 5'b01011;
         4'h6: code = 5'b01110;
         4'h7: code = 5'b01111;
         4'h8: code = 5'b10010;
         4'h9: code = 5'b10011;
         4'hA: code = 5'b10110;
         4'hB: code = 5'b10111;
         4'hC: code = 5'b11010;
         4'hD: code = 5'b11011;
         4'hE: code = 5'b11100;
         default: code = 5'b11101;
      endcase
   end
endmodule

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
   import fe_pcs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_er,
   input  nib_t txd,
   output sym_t sym_plain
);
   frm_state_t state_q, state_d;
   sym_t       sym_q, sym_d;
   sym_t       data_code;

   fe_tx_enc4b5b u_enc (
      .nib  (txd),
      .code (data_code)
   );

   // One decision per edge: choose the next code group and the next state.
   always_comb begin
      state_d = state_q;
      sym_d   = SYM_IDLE;
      unique case (state_q)
         ST_IDLE: begin
            if (tx_en) begin
               sym_d   = SYM_J;
               state_d = ST_K;
            end
         end
         ST_K: begin
            if (tx_en) begin
               sym_d   = SYM_K;
               state_d = ST_DATA;
            end else begin
               sym_d   = SYM_T;
               state_d = ST_R;
            end
         end
         ST_DATA: begin
            if (!tx_en) begin
               sym_d   = SYM_T;
               state_d = ST_R;
            end else if (tx_er) begin
               sym_d   = SYM_H;
            end else begin
               sym_d   = data_code;
            end
         end
         default: begin
            sym_d   = SYM_R;
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sym_q   <= SYM_IDLE;
      end else begin
         state_q <= state_d;
         sym_q   <= sym_d;
      end
   end

   assign sym_plain = sym_q;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (sym_q == SYM_IDLE && state_q == ST_IDLE));

   assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !tx_en) |=> sym_q == SYM_IDLE);

   assert_j_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && tx_en) |=> sym_q == SYM_J);

   assert_k_or_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_q == SYM_J) |=> (sym_q == SYM_K || sym_q == SYM_T));

   assert_error_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && tx_en && tx_er) |=> sym_q == SYM_H);

   assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_q == SYM_T) |=> sym_q == SYM_R);

   assert_r_then_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_q == SYM_R) |=> (sym_q == SYM_IDLE || sym_q == SYM_J));
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler
   import fe_pcs_pkg::*;
#(
   parameter int          LEN  = 11,
   parameter int          TAP  = 9,
   parameter int unsigned SEED = 'h5A5
) (
   input  logic clk,
   input  logic rst_n,
   input  sym_t sym_in,
   output sym_t sym_out
);
   localparam logic [LEN-1:0] SEED_V = LEN'(SEED);

   logic [LEN-1:0] lfsr_q;
   logic [LEN-1:0] walk;
   sym_t           key;

   // Run SYM_W feedback steps on a copy; the first bit lands in the MSB.
   always_comb begin
      logic fb;
      walk = lfsr_q;
      key  = '0;
      for (int i = 0; i < SYM_W; i++) begin
         fb                = walk[LEN-1] ^ walk[TAP-1];
         key[SYM_W-1-i]    = fb;
         walk              = {walk[LEN-2:0], fb};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= SEED_V;
      else        lfsr_q <= walk;
   end

   assign sym_out = sym_in ^ key;

   assert_seed_load_R9: assert property (@(posedge clk)
      !rst_n |=> lfsr_q == SEED_V);

   assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

// File: rtl/fe_tx_pcs.sv
module fe_tx_pcs
   import fe_pcs_pkg::*;
#(
   parameter bit          SCR_EN   = 1'b1,
   parameter int          SCR_LEN  = 11,
   parameter int          SCR_TAP  = 9,
   parameter int unsigned SCR_SEED = 'h5A5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       tx_er,
   input  logic [3:0] txd,
   output logic [4:0] tx_sym
);
   if (SCR_LEN < SYM_W + 1) begin : g_bad_len
      $error("fe_tx_pcs: SCR_LEN too short");
   end
   if (SCR_TAP < 1 || SCR_TAP >= SCR_LEN) begin : g_bad_tap
      $error("fe_tx_pcs: SCR_TAP out of range");
   end
   if ((SCR_SEED % (64'd1 << SCR_LEN)) == 0) begin : g_bad_seed
      $error("fe_tx_pcs: SCR_SEED must be non-zero");
   end

   sym_t plain;

   fe_tx_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .tx_er     (tx_er),
      .txd       (txd),
      .sym_plain (plain)
   );

   if (SCR_EN) begin : g_scr
      fe_tx_scrambler #(
         .LEN  (SCR_LEN),
         .TAP  (SCR_TAP),
         .SEED (SCR_SEED)
      ) u_scr (
         .clk     (clk),
         .rst_n   (rst_n),
         .sym_in  (plain),
         .sym_out (tx_sym)
      );
   end else begin : g_plain
      assign tx_sym = plain;
   end
endmodule

// File: tb/fe_tx_pcs_bench.sv
module fe_tx_pcs_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_en, tx_er;
   logic [3:0] txd;
   logic [4:0] sym_plain, sym_scr;
   logic [10:0] m_s;
   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   fe_tx_pcs #(.SCR_EN(1'b0)) u_fe_tx_pcs (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_sym(sym_plain));
   fe_tx_pcs #(.SCR_EN(1'b1)) u_fe_tx_pcs_scr (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_sym(sym_scr));

   // {tx_en, tx_er, txd, expected plain code group}
   localparam logic [10:0] VEC [30] = '{
      {1'b0,1'b0,4'h0,5'b11111},  // R2
      {1'b0,1'b1,4'h5,5'b11111},  // R7
      {1'b1,1'b0,4'h5,5'b11000},  // R3 J
      {1'b1,1'b1,4'h5,5'b10001},  // R3 K, R10
      {1'b1,1'b0,4'h0,5'b11110},
      {1'b1,1'b0,4'h1,5'b01001},
      {1'b1,1'b0,4'h2,5'b10100},
      {1'b1,1'b0,4'h3,5'b10101},
      {1'b1,1'b0,4'h4,5'b01010},
      {1'b1,1'b0,4'h5,5'b01011},
      {1'b1,1'b0,4'h6,5'b01110},
      {1'b1,1'b0,4'h7,5'b01111},
      {1'b1,1'b0,4'h8,5'b10010},
      {1'b1,1'b0,4'h9,5'b10011},
      {1'b1,1'b0,4'hA,5'b10110},
      {1'b1,1'b0,4'hB,5'b10111},
      {1'b1,1'b0,4'hC,5'b11010},
      {1'b1,1'b0,4'hD,5'b11011},
      {1'b1,1'b0,4'hE,5'b11100},
      {1'b1,1'b0,4'hF,5'b11101},
      {1'b1,1'b1,4'h7,5'b00100},  // R5 H
      {1'b1,1'b0,4'hF,5'b11101},
      {1'b0,1'b0,4'h0,5'b01101},  // R6 T
      {1'b0,1'b1,4'h3,5'b00111},  // R6 R
      {1'b0,1'b1,4'h0,5'b11111},  // R7
      {1'b0,1'b0,4'h0,5'b11111},
      {1'b1,1'b0,4'h5,5'b11000},  // R8 J
      {1'b0,1'b0,4'h5,5'b01101},  // R8 T in place of K
      {1'b0,1'b0,4'h0,5'b00111},  // R8 R
      {1'b0,1'b0,4'h0,5'b11111}
   };

   function automatic logic [4:0] key_of(logic [10:0] s);
      logic [4:0] k;
      for (int i = 0; i < 5; i++) begin
         logic b;
         b = s[10] ^ s[8];
         k[4-i] = b;
         s = {s[9:0], b};
      end
      return k;
   endfunction

   function automatic logic [10:0] step_of(logic [10:0] s);
      for (int i = 0; i < 5; i++) s = {s[9:0], s[10] ^ s[8]};
      return s;
   endfunction

   task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Drive at the falling edge, clock one rising edge, sample at the next falling edge.
   task automatic cycle(logic en, logic er, logic [3:0] d, logic rn);
      rst_n = rn; tx_en = en; tx_er = er; txd = d;
      @(posedge clk);
      if (!rn) m_s = 11'h5A5;
      else     m_s = step_of(m_s);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      m_s = 11'h5A5;
      rst_n = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
      @(negedge clk);
      cycle(1'b1, 1'b1, 4'h3, 1'b0);
      cycle(1'b1, 1'b0, 4'h3, 1'b0);
      chk("R1 reset idle", sym_plain, 5'b11111);
      chk("R9 reset seed key", sym_scr, 5'b11111 ^ key_of(11'h5A5));

      for (int v = 0; v < 30; v++) begin
         cycle(VEC[v][10], VEC[v][9], VEC[v][8:5], 1'b1);
         chk($sformatf("R2/R3/R4/R5/R6/R7/R8/R10 vector %0d", v), sym_plain, VEC[v][4:0]);
         chk($sformatf("R9 scrambled vector %0d", v), sym_scr, VEC[v][4:0] ^ key_of(m_s));
      end

      // R1: reset in mid-frame drops the frame; enable held high reopens with J.
      cycle(1'b1, 1'b0, 4'h5, 1'b1);
      cycle(1'b1, 1'b0, 4'h5, 1'b1);
      cycle(1'b1, 1'b0, 4'h2, 1'b1);
      chk("R4 before reset", sym_plain, 5'b10100);
      cycle(1'b1, 1'b0, 4'h2, 1'b0);
      chk("R1 mid-frame reset", sym_plain, 5'b11111);
      chk("R1 mid-frame reseed", sym_scr, 5'b11111 ^ key_of(11'h5A5));
      cycle(1'b1, 1'b0, 4'h2, 1'b1);
      chk("R1 restart J", sym_plain, 5'b11000);
      chk("R9 restart key", sym_scr, 5'b11000 ^ key_of(m_s));
      cycle(1'b1, 1'b1, 4'h2, 1'b1);
      chk("R10 K under error", sym_plain, 5'b10001);
      cycle(1'b1, 1'b1, 4'h0, 1'b1);
      chk("R5 H first data", sym_plain, 5'b00100);
      cycle(1'b0, 1'b1, 4'h0, 1'b1);
      chk("R6 T with error high", sym_plain, 5'b01101);
      cycle(1'b1, 1'b0, 4'h9, 1'b1);
      chk("R6 R ignores enable", sym_plain, 5'b00111);
      cycle(1'b0, 1'b0, 4'h0, 1'b1);
      chk("R2 idle after R", sym_plain, 5'b11111);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule